// File: doc/BRIEF.md
# DRAM Burst Read Wait-State Sequencer

This block times a four-word burst read from a 32-bit DRAM bank. It does not drive row or column strobes and does not multiplex addresses. It turns a start pulse into a per-cycle data-ready strobe, a word index and a done pulse. The number of idle cycles before the first word, and between later words, comes from a small matrix. The matrix is indexed by three settings: the bus-frequency class, the DRAM type (fast-page or EDO), and whether an external data latch sits on the DRAM data path.

A CPU burst and a DMA burst follow the same timing. The DMA flag travels with the request but changes nothing. The configuration is captured on the cycle the start is accepted and is held until the burst ends. A start that arrives while a burst is running is dropped.

Cycle numbering: cycle 1 is the clock cycle right after the rising edge that samples `start_i` high while the block is idle. Frequency codes on `freq_sel_i` are 2'b00 = 33 MHz, 2'b01 = 25 MHz, 2'b10 = 20/16 MHz and 2'b11 = treated as 33 MHz.

Top module: `dram_rd_seq`

## Requirements
- R1: After reset, and until the first accepted start, `data_rdy_o` and `done_o` are 0 and `word_idx_o` is 0.
- R2: With `freq_sel_i` 2'b00 or 2'b11, EDO (`edo_i`=1) gives data in cycles 3,4,5,6. Fast-page (`edo_i`=0) gives data in cycles 3,5,7,9, whatever `latch_i` is.
- R3: With `freq_sel_i`=2'b01 and either `edo_i`=1 or `latch_i`=1, data is in cycles 2,3,4,5.
- R4: With `freq_sel_i`=2'b01, `edo_i`=0 and `latch_i`=0, data is in cycles 3,5,7,9.
- R5: With `freq_sel_i`=2'b10 and either `edo_i`=1 or `latch_i`=1, data is in cycles 1,2,3,4.
- R6: With `freq_sel_i`=2'b10, `edo_i`=0 and `latch_i`=0, data is in cycles 3,5,7,9.
- R7: `dma_i` has no effect on the strobe pattern, the index or the done pulse.
- R8: On the n-th data strobe (n = 0..3), `word_idx_o` equals n. The index changes only in the cycle after a data strobe, and it returns to 0 after the fourth word.
- R9: `done_o` is 1 exactly in the cycle of the fourth data strobe and at no other time.
- R10: A start sampled while a burst is running, including during its final data cycle, is ignored. No extra strobes follow the burst.
- R11: Configuration inputs are sampled only when a start is accepted. Changing them during a burst does not alter that burst.
- R12: A start sampled in the first idle cycle after `done_o` is accepted and produces a normal burst.
- R13: An asynchronous reset during a burst ends it. The outputs return to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request pulse |
| freq_sel_i | input | 2 | Bus-frequency class code |
| edo_i | input | 1 | 1 = EDO DRAM, 0 = fast-page DRAM |
| latch_i | input | 1 | 1 = external data latch fitted |
| dma_i | input | 1 | Request comes from DMA (timing unchanged) |
| data_rdy_o | output | 1 | Data word valid this cycle |
| word_idx_o | output | 2 | Index of the current or next word |
| done_o | output | 1 | Fourth word valid this cycle |

## Verification
The end of one burst and the arrival of the next request can fall in the same cycle: the fourth data strobe with its done pulse, and a new start. The bench raises `start_i` during the final data cycle and then checks several more cycles for silence, which shows the start was dropped. It then issues a start in the first idle cycle after done and expects a complete, correctly timed burst. A configuration change partway through a burst is also judged, by comparing every cycle of the strobe pattern against the pattern of the configuration captured at start.

// File: rtl/dram_rd_seq_pkg.sv
package dram_rd_seq_pkg;

  localparam int WAIT_W = 2;

  typedef enum logic [1:0] {
    FREQ_33    = 2'b00,
    FREQ_25    = 2'b01,
    FREQ_20_16 = 2'b10,
    FREQ_RSVD  = 2'b11
  } freq_class_e;

  typedef struct packed {
    logic [WAIT_W-1:0] first_wait;
    logic [WAIT_W-1:0] gap_wait;
  } rd_timing_t;

endpackage

// File: rtl/dram_rd_timing_lut.sv
module dram_rd_timing_lut
  import dram_rd_seq_pkg::*;
(
  input  logic [1:0]  freq_sel_i,
  input  logic        edo_i,
  input  logic        latch_i,
  output rd_timing_t  timing_o
);

  localparam logic [WAIT_W-1:0] SLOW_FIRST = WAIT_W'(2);
  localparam logic [WAIT_W-1:0] SLOW_GAP   = WAIT_W'(1);

  freq_class_e freq_cls;
  logic        fast_path;

  assign freq_cls  = freq_class_e'(freq_sel_i);
  // latch lets fast-page data be captured like EDO below 33 MHz
  assign fast_path = edo_i | latch_i;

  always_comb begin
    timing_o.first_wait = SLOW_FIRST;
    timing_o.gap_wait   = SLOW_GAP;
    unique case (freq_cls)
      FREQ_25: begin
        if (fast_path) begin
          timing_o.first_wait = WAIT_W'(1);
          timing_o.gap_wait   = '0;
        end
      end
      FREQ_20_16: begin
        if (fast_path) begin
          timing_o.first_wait = '0;
          timing_o.gap_wait   = '0;
        end
      end
      default: begin
        // 33 MHz class and reserved code: latch does not help
        if (edo_i) timing_o.gap_wait = '0;
      end
    endcase
  end

  always_comb begin
    AST_WAIT_RANGE: assert (timing_o.first_wait <= SLOW_FIRST && timing_o.gap_wait <= SLOW_GAP); // R2
  end

endmodule

// File: rtl/dram_rd_burst_ctrl.sv
module dram_rd_burst_ctrl #(
  parameter  int NUM_WORDS = 4,
  parameter  int WAIT_W    = 2,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] first_wait_i,
  input  logic [WAIT_W-1:0] gap_wait_i,
  output logic              busy_o,
  output logic              data_rdy_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic              busy_q;
  logic              rdy_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] gap_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last_w;
  logic              accept_w;

  assign last_w   = (idx_q == LAST_IDX);
  assign accept_w = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      cnt_q  <= '0;
      gap_q  <= '0;
      idx_q  <= '0;
    end else if (accept_w) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      gap_q  <= gap_wait_i;
      if (first_wait_i == '0) begin
        rdy_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        rdy_q <= 1'b0;
        cnt_q <= first_wait_i - WAIT_W'(1);
      end
    end else if (busy_q) begin
      if (rdy_q) begin
        if (last_w) begin
          busy_q <= 1'b0;
          rdy_q  <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          if (gap_q == '0) begin
            rdy_q <= 1'b1;
          end else begin
            rdy_q <= 1'b0;
            cnt_q <= gap_q - WAIT_W'(1);
          end
        end
      end else if (cnt_q == '0) begin
        rdy_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - WAIT_W'(1);
      end
    end
  end

  assign busy_o     = busy_q;
  assign data_rdy_o = rdy_q;
  assign word_idx_o = idx_q;
  assign done_o     = rdy_q && last_w;

  AST_IDX_HOLD_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rdy_q) |=> $stable(idx_q)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (!rdy_q && idx_q == '0)); // R1
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!rdy_q && !busy_q)); // R10
  AST_GAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> $stable(gap_q)); // R11
  AST_ZERO_GAP_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !last_w && gap_q == '0) |=> rdy_q); // R3

endmodule

// File: rtl/dram_rd_seq.sv
module dram_rd_seq
  import dram_rd_seq_pkg::*;
#(
  parameter  int NUM_WORDS = 4,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       freq_sel_i,
  input  logic             edo_i,
  input  logic             latch_i,
  input  logic             dma_i,
  output logic             data_rdy_o,
  output logic [IDX_W-1:0] word_idx_o,
  output logic             done_o
);

  rd_timing_t timing_w;
  logic       busy_w;

  dram_rd_timing_lut u_lut (
    .freq_sel_i (freq_sel_i),
    .edo_i      (edo_i),
    .latch_i    (latch_i),
    .timing_o   (timing_w)
  );

  // CPU and DMA requests share one timing path
  dram_rd_burst_ctrl #(
    .NUM_WORDS (NUM_WORDS),
    .WAIT_W    (WAIT_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .first_wait_i (timing_w.first_wait),
    .gap_wait_i   (timing_w.gap_wait),
    .busy_o       (busy_w),
    .data_rdy_o   (data_rdy_o),
    .word_idx_o   (word_idx_o),
    .done_o       (done_o)
  );

  AST_DMA_ACCEPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && dma_i && !busy_w) |=> busy_w); // R7
  AST_NO_FAST_AT_33: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_w && freq_sel_i == 2'b00) |=> !data_rdy_o); // R2

endmodule

// File: tb/tb_dram_rd_seq.sv
module tb_dram_rd_seq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] freq = 2'b00;
  logic       edo = 1'b0;
  logic       latch = 1'b0;
  logic       dma = 1'b0;
  logic       rdy;
  logic [1:0] idx;
  logic       done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_rd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_sel_i(freq),
    .edo_i(edo), .latch_i(latch), .dma_i(dma),
    .data_rdy_o(rdy), .word_idx_o(idx), .done_o(done)
  );

  // {freq[1:0], edo, latch, dma, first_wait[1:0], gap}
  localparam logic [7:0] VEC [16] = '{
    8'b00_0_0_0_10_1, 8'b00_0_1_1_10_1, 8'b00_1_0_0_10_0, 8'b00_1_1_1_10_0,
    8'b01_0_0_1_10_1, 8'b01_0_1_0_01_0, 8'b01_1_0_1_01_0, 8'b01_1_1_0_01_0,
    8'b10_0_0_0_10_1, 8'b10_0_1_1_00_0, 8'b10_1_0_0_00_0, 8'b10_1_1_1_00_0,
    8'b11_0_0_1_10_1, 8'b11_0_1_0_10_1, 8'b11_1_0_1_10_0, 8'b11_1_1_0_10_0
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string req_of(input logic [1:0] f, input logic e, input logic l);
    if (f == 2'b01) return (e || l) ? "R3" : "R4";
    if (f == 2'b10) return (e || l) ? "R5" : "R6";
    return "R2";
  endfunction

  // Call at a negedge. Samples cycles 1..ncyc at negedges.
  task automatic run_burst(input logic [1:0] f, input logic e, input logic l,
                           input logic d, input int w, input int g,
                           input int ncyc, input int restart_at,
                           input int flip_at, input string tag);
    int seen = 0;
    freq = f; edo = e; latch = l; dma = d;
    start = 1'b1;
    for (int c = 1; c <= ncyc; c++) begin
      int k;
      bit exp_rdy;
      @(negedge clk);
      k = c - (w + 1);
      exp_rdy = (k >= 0) && (k % (g + 1) == 0) && (k / (g + 1) < 4);
      chk(rdy == exp_rdy, tag, $sformatf("data_rdy cycle %0d", c), rdy, exp_rdy);
      chk(done == (exp_rdy && seen == 3), "R9", $sformatf("done cycle %0d", c),
          done, exp_rdy && seen == 3);
      chk(idx == 2'(seen % 4), "R8", $sformatf("word_idx cycle %0d", c), idx, seen % 4);
      if (exp_rdy) seen++;
      start = (c == restart_at);
      if (c == flip_at) begin
        freq = (f == 2'b10) ? 2'b00 : 2'b10;
        edo = ~e; latch = ~l; dma = ~d;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy == 1'b0, "R1", "data_rdy in reset", rdy, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rdy == 1'b0 && done == 1'b0, "R1", "outputs idle after reset", rdy | done, 0);
    chk(idx == 2'd0, "R1", "word_idx after reset", idx, 0);

    // Matrix walk; dma toggles across entries (R7)
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = VEC[i];
      run_burst(v[7:6], v[5], v[4], v[3], int'(v[2:1]), int'(v[0]), 12, 0, 0,
                req_of(v[7:6], v[5], v[4]));
    end

    // R7: same config, both dma values
    run_burst(2'b01, 1'b0, 1'b0, 1'b1, 2, 1, 11, 0, 0, "R7");
    run_burst(2'b01, 1'b0, 1'b0, 1'b0, 2, 1, 11, 0, 0, "R7");

    // R10: start mid-burst ignored
    run_burst(2'b00, 1'b0, 1'b0, 1'b0, 2, 1, 14, 4, 0, "R10");
    // R10: start on the done cycle (cycle 9) ignored
    run_burst(2'b00, 1'b0, 1'b0, 1'b0, 2, 1, 15, 9, 0, "R10");
    // R10 with zero-wait burst: start on done cycle 4
    run_burst(2'b10, 1'b1, 1'b0, 1'b0, 0, 0, 10, 4, 0, "R10");

    // R11: config flips during wait and during data
    run_burst(2'b00, 1'b0, 1'b0, 1'b0, 2, 1, 12, 1, 1, "R11");
    run_burst(2'b10, 1'b1, 1'b1, 1'b0, 0, 0, 8, 0, 2, "R11");

    // R12: start in the first idle cycle after done
    run_burst(2'b01, 1'b1, 1'b0, 1'b0, 1, 0, 6, 0, 0, "R12");
    run_burst(2'b10, 1'b0, 1'b1, 1'b1, 0, 0, 5, 0, 0, "R12");
    run_burst(2'b00, 1'b1, 1'b0, 1'b0, 2, 0, 8, 0, 0, "R12");

    // R13: reset mid-burst
    freq = 2'b00; edo = 1'b0; latch = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(rdy == 1'b1, "R13", "data before reset", rdy, 1);
    rst_n = 1'b0;
    #1;
    chk(rdy == 1'b0 && done == 1'b0, "R13", "outputs cleared by reset", rdy | done, 0);
    chk(idx == 2'd0, "R13", "word_idx cleared by reset", idx, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdy == 1'b0, "R13", "no resumed burst", rdy, 0);
    run_burst(2'b10, 1'b1, 1'b0, 1'b0, 0, 0, 6, 0, 0, "R13");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule